// File: doc/BRIEF.md
# Repeating Block Scan and Port Transfer Sequencer

This block runs a repeating block operation in hardware, one element per iteration, until that operation's own stop rule holds. A start strobe loads three things: the 16-bit pointer (HL), the 16-bit count register (BC) and the 8-bit key (A). The strobe's operation code picks one of three loops. Scan-down compares memory bytes against the key. Port-to-memory fills memory from an I/O port. Memory-to-port drains memory out to an I/O port. The pointer moves downward in every mode.

The loops differ in when they stop. Scan-down stops when it finds a byte equal to the key, or when the full 16-bit count runs out. The two port loops count only the high byte (B) and stop when it reaches zero. The low byte (C) is the port number and never changes. When the run ends, the block pulses a done signal. It then holds the final pointer, count and zero flag until the next accepted start.

Top module: `blkrep_engine`

## Requirements
- R1: After reset, busy, done and all four bus strobes (mem_rd, mem_wr, io_rd, io_wr) are low.
- R2: A start is accepted only while idle and only with op 0 (scan-down), 1 (port-to-memory) or 2 (memory-to-port). A start with op 3, or a start while busy, changes no output and no outcome.
- R3: In scan-down, each iteration reads memory at the current pointer. It then decrements both the pointer and the 16-bit count by one.
- R4: Scan-down stops after the iteration whose byte equals the key. zf is then 1, and the pointer and count have already been decremented past that byte.
- R5: Scan-down with no match stops when the count reaches 0, with zf = 0. A starting count of 0 wraps through 65535, so it allows 65536 iterations.
- R6: Port-to-memory reads the port at address {B,C} and writes that byte to memory at the pointer. It then decrements B and the pointer. C is unchanged.
- R7: Memory-to-port reads memory at the pointer and writes that byte to the port at address {B,C}. It then decrements B and the pointer.
- R8: The port loops stop when B reaches 0, with zf = 1. A starting B of 0 runs 256 iterations.
- R9: Every iteration takes exactly 3 cycles: an access cycle, a transfer-or-compare cycle and an update cycle. At most one bus strobe is high in any cycle, and none is high while idle.
- R10: done is a single-cycle pulse in the first idle cycle after the final update. hl_out, bc_out and zf hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe |
| op | input | 2 | Operation: 0 scan-down, 1 port-to-memory, 2 memory-to-port, 3 reserved |
| hl_in | input | 16 | Starting pointer |
| bc_in | input | 16 | Starting count; high byte B, low byte C |
| a_in | input | 8 | Key byte for scan-down |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hl_out | output | 16 | Current or final pointer |
| bc_out | output | 16 | Current or final count |
| zf | output | 1 | Zero flag: match found, or B reached 0 |
| mem_addr | output | 16 | Memory address (the pointer) |
| mem_rd | output | 1 | Memory read strobe; data sampled at the end of the cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| io_addr | output | 16 | Port address, {B,C} |
| io_rd | output | 1 | Port read strobe; data sampled at the end of the cycle |
| io_wr | output | 1 | Port write strobe |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data |

## Verification
Properties that hold on every cycle are checked continuously: only one strobe at a time, no strobes while idle, done lasting one cycle and never overlapping busy, results holding steady while idle, a reserved op never starting a run, and each write carrying the byte read in the cycle before. The stop rules can only be shown by the bench's scenarios, run against a cycle-accurate reference model. These include a match part-way through the buffer, count exhaustion with no match, the 16-bit count wrapping from 0, the 256-iteration run from B = 0, and a start arriving mid-run.

// File: rtl/blkrep_engine.sv
module blkrep_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [15:0] hl_in,
  input  logic [15:0] bc_in,
  input  logic [7:0]  a_in,
  output logic        busy,
  output logic        done,
  output logic [15:0] hl_out,
  output logic [15:0] bc_out,
  output logic        zf,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] io_addr,
  output logic        io_rd,
  output logic        io_wr,
  output logic [7:0]  io_wdata,
  input  logic [7:0]  io_rdata
);
  localparam logic [1:0] OP_SCAN = 2'd0, OP_PIN = 2'd1, OP_POUT = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_XFR, ST_UPD} st_t;

  st_t         st;
  logic [1:0]  mode;
  logic [15:0] hl, bc;
  logic [7:0]  key, dat;
  logic        zf_q, done_q;

  logic [15:0] bc_dec;
  logic [7:0]  b_dec;
  logic        hit, stop;

  assign bc_dec = bc - 16'd1;
  assign b_dec  = bc[15:8] - 8'd1;
  assign hit    = (dat == key);
  assign stop   = (mode == OP_SCAN) ? (hit || bc_dec == 16'd0) : (b_dec == 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode   <= OP_SCAN;
      hl     <= '0;
      bc     <= '0;
      key    <= '0;
      dat    <= '0;
      zf_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start && op != 2'd3) begin
          mode <= op;
          hl   <= hl_in;
          bc   <= bc_in;
          key  <= a_in;
          zf_q <= 1'b0;
          st   <= ST_ACC;
        end
        ST_ACC: begin
          dat <= (mode == OP_PIN) ? io_rdata : mem_rdata;
          st  <= ST_XFR;
        end
        ST_XFR: st <= ST_UPD;
        ST_UPD: begin
          hl <= hl - 16'd1;
          if (mode == OP_SCAN) begin
            bc   <= bc_dec;
            zf_q <= hit;
          end else begin
            bc[15:8] <= b_dec;
            zf_q     <= (b_dec == 8'd0);
          end
          if (stop) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= ST_ACC;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign hl_out    = hl;
  assign bc_out    = bc;
  assign zf        = zf_q;
  assign mem_addr  = hl;
  assign io_addr   = bc;
  assign mem_rd    = (st == ST_ACC) && (mode != OP_PIN);
  assign io_rd     = (st == ST_ACC) && (mode == OP_PIN);
  assign mem_wr    = (st == ST_XFR) && (mode == OP_PIN);
  assign io_wr     = (st == ST_XFR) && (mode == OP_POUT);
  assign mem_wdata = dat;
  assign io_wdata  = dat;
endmodule

module blkrep_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  op,
  input logic        busy,
  input logic        done,
  input logic [15:0] hl_out,
  input logic [15:0] bc_out,
  input logic        zf,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  mem_rdata,
  input logic        io_rd,
  input logic        io_wr,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata
);
  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr || io_rd || io_wr));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hl_out) && $stable(bc_out) && $stable(zf)));
  // R2
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op == 2'd3) |=> !busy);
  // R6
  pin_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(io_rd) && mem_wdata == $past(io_rdata)));
  // R7
  pout_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> ($past(mem_rd) && io_wdata == $past(mem_rdata)));
endmodule

bind blkrep_engine blkrep_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .busy(busy), .done(done),
  .hl_out(hl_out), .bc_out(bc_out), .zf(zf),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
  .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata)
);

// File: tb/blkrep_engine_tb.sv
module blkrep_engine_tb;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [1:0]  op = 0;
  logic [15:0] hl_in = 0, bc_in = 0;
  logic [7:0]  a_in = 0;
  logic        busy, done, zf, mem_rd, mem_wr, io_rd, io_wr;
  logic [15:0] hl_out, bc_out, mem_addr, io_addr;
  logic [7:0]  mem_wdata, mem_rdata, io_wdata, io_rdata;

  int checks = 0, failures = 0;
  logic [7:0] mem [0:4095];
  logic [23:0] out_log [$];

  always #4 clk = ~clk;

  blkrep_engine u_dut (.*);

  function automatic logic [7:0] io_fn(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
  endfunction

  assign mem_rdata = mem[mem_addr[11:0]];
  assign io_rdata  = io_fn(io_addr);

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
    if (io_wr) out_log.push_back({io_addr, io_wdata});
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      if (failures < 30) $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_busy, m_done, m_zf;
  int          m_ph, m_mode;
  logic [15:0] m_hl, m_bc;
  logic [7:0]  m_a, m_byte;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_zf = 0; m_ph = 0; m_mode = 0;
      m_hl = 0; m_bc = 0; m_a = 0; m_byte = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start && op != 2'd3) begin
          m_busy = 1; m_mode = op; m_hl = hl_in; m_bc = bc_in;
          m_a = a_in; m_zf = 0; m_ph = 0;
        end
      end else if (m_ph == 0) begin
        m_byte = (m_mode == 1) ? io_fn(m_bc) : mem[m_hl[11:0]];
        m_ph = 1;
      end else if (m_ph == 1) begin
        m_ph = 2;
      end else begin
        bit fin;
        m_ph = 0;
        m_hl = m_hl - 1;
        if (m_mode == 0) begin
          m_bc = m_bc - 1;
          m_zf = (m_byte == m_a);
          fin  = m_zf || (m_bc == 0);
        end else begin
          m_bc[15:8] = m_bc[15:8] - 1;
          m_zf = (m_bc[15:8] == 0);
          fin  = m_zf;
        end
        if (fin) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [3:0] es;
    es = {m_busy && m_ph == 0 && m_mode != 1, m_busy && m_ph == 1 && m_mode == 1,
          m_busy && m_ph == 0 && m_mode == 1, m_busy && m_ph == 1 && m_mode == 2};
    check(busy == m_busy && done == m_done, "R10", "busy/done",
          {busy, done}, {m_busy, m_done});
    check(hl_out == m_hl && bc_out == m_bc && zf == m_zf, "R3", "hl/bc/zf",
          {hl_out, bc_out}, {m_hl, m_bc});
    check({mem_rd, mem_wr, io_rd, io_wr} == es, "R9", "strobes",
          {mem_rd, mem_wr, io_rd, io_wr}, es);
    if (mem_wr) check(mem_wdata == m_byte, "R6", "mem_wdata", mem_wdata, m_byte);
    if (io_wr)  check(io_wdata == m_byte, "R7", "io_wdata", io_wdata, m_byte);
    if (mem_rd || mem_wr) check(mem_addr == m_hl, "R3", "mem_addr", mem_addr, m_hl);
    if (io_rd || io_wr)   check(io_addr == m_bc, "R6", "io_addr", io_addr, m_bc);
  end

  task automatic run(input logic [1:0] o, input logic [15:0] h, input logic [15:0] b,
                     input logic [7:0] a, input bit poke, output int cyc);
    @(negedge clk);
    op = o; hl_in = h; bc_in = b; a_in = a; start = 1;
    @(negedge clk);
    start = 0; hl_in = 16'hFFFF; bc_in = 16'h0001; op = 2'd0;
    cyc = 0;
    while (!done) begin
      if (busy) cyc++;
      start = (poke && cyc == 4);
      @(negedge clk);
    end
    start = 0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] h0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem[12'h102] = 8'h3C;
    mem[12'h2FC] = 8'h77;
    mem[12'h500] = 8'hC1;
    mem[12'h4FF] = 8'h2D;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !mem_rd && !mem_wr && !io_rd && !io_wr, "R1", "reset outputs",
          {busy, done, mem_rd, mem_wr, io_rd, io_wr}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 reserved op ignored
    op = 2'd3; hl_in = 16'h1234; bc_in = 16'h0005; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    check(!busy && hl_out == 16'h0000, "R2", "reserved op", {busy, hl_out}, 0);

    // R4 match part-way
    run(2'd0, 16'h0105, 16'd10, 8'h3C, 0, cyc);
    check(hl_out == 16'h0101 && bc_out == 16'd6 && zf, "R4", "scan match",
          {zf, hl_out, bc_out}, {1'b1, 16'h0101, 16'd6});
    check(cyc == 12, "R9", "scan cycles", cyc, 12);

    // R5 exhaust without match
    run(2'd0, 16'h0200, 16'd3, 8'hEE, 0, cyc);
    check(hl_out == 16'h01FD && bc_out == 16'd0 && !zf, "R5", "scan exhaust",
          {zf, hl_out, bc_out}, {1'b0, 16'h01FD, 16'd0});

    // R5 count 0 wraps
    run(2'd0, 16'h0300, 16'd0, 8'h77, 0, cyc);
    check(hl_out == 16'h02FB && bc_out == 16'hFFFB && zf, "R5", "scan wrap",
          {zf, hl_out, bc_out}, {1'b1, 16'h02FB, 16'hFFFB});

    // R6 R8 port-to-memory
    run(2'd1, 16'h0400, 16'h0312, 8'h00, 0, cyc);
    check(mem[12'h400] == io_fn(16'h0312) && mem[12'h3FF] == io_fn(16'h0212) &&
          mem[12'h3FE] == io_fn(16'h0112), "R6", "filled bytes",
          mem[12'h3FE], io_fn(16'h0112));
    check(bc_out == 16'h0012 && hl_out == 16'h03FD && zf, "R8", "port-in end",
          {zf, hl_out, bc_out}, {1'b1, 16'h03FD, 16'h0012});

    // R7 memory-to-port with a mid-run start (R2)
    out_log.delete();
    run(2'd2, 16'h0500, 16'h0277, 8'h00, 1, cyc);
    check(out_log.size() == 2, "R7", "port write count", out_log.size(), 2);
    if (out_log.size() == 2) begin
      check(out_log[0] == {16'h0277, 8'hC1}, "R7", "first port write", out_log[0], {16'h0277, 8'hC1});
      check(out_log[1] == {16'h0177, 8'h2D}, "R7", "second port write", out_log[1], {16'h0177, 8'h2D});
    end
    check(hl_out == 16'h04FE && bc_out == 16'h0077, "R2", "start while busy ignored",
          {hl_out, bc_out}, {16'h04FE, 16'h0077});

    // R8 B = 0 runs 256 iterations
    run(2'd1, 16'h0800, 16'h0045, 8'h00, 0, cyc);
    check(cyc == 768, "R8", "256 iterations", cyc, 768);
    check(hl_out == 16'h0700 && bc_out == 16'h0045 && zf, "R8", "B=0 end",
          {zf, hl_out, bc_out}, {1'b1, 16'h0700, 16'h0045});
    check(mem[12'h800] == io_fn(16'h0045) && mem[12'h701] == io_fn(16'h0145), "R6",
          "B=0 fill ends", mem[12'h701], io_fn(16'h0145));

    // R10 hold after done
    h0 = hl_out;
    repeat (5) @(negedge clk);
    check(!done && !busy && hl_out == h0 && bc_out == 16'h0045 && zf, "R10", "hold",
          {done, busy, hl_out}, {2'b00, h0});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule